// File: doc/BRIEF.md
# Watchdog Timer with Selectable Unit and Reset Pulse

This block is a watchdog that a host programs through a small byte-wide register bus. An 8-bit down-counter is decremented once per time unit. The unit is either one second or one minute, and both are built by dividing an incoming one-millisecond tick. Software keeps the system alive by writing the count register again before the counter runs out. Each such write reloads the counter and restarts the unit divider.

When the counter runs out, the block latches a sticky timeout flag and pulls its active-low reset pin. The pin can be held low as a level, or driven low for one of four programmed pulse widths. Counting requires two enables: the device enable and the watchdog enable. The pin is driven only while the output enable is set. Software clears the timeout flag by writing a one to it.

The division ratios are parameters, so a test build can shrink a second to a few ticks.

Top module: `wdog_top`

## Requirements
- R1: After reset all four registers read 0 and `wdt_rst_n` is high.
- R2: Register map (2-bit address). Address 0, bit 0 is the device enable. Address 1, bit 7 is the output enable. Address 2 is the configuration byte: bit 6 timeout status, bit 5 watchdog enable, bit 4 pulse mode, bit 3 minute unit, bits 1:0 pulse width code; bits 7 and 2 read 0. Address 3 reads the live counter.
- R3: The counter holds its value unless both the device enable and the watchdog enable are 1.
- R4: Expiry happens count×MS_PER_SEC ms ticks after enabling or reloading in second unit (bit 3 = 0). In minute unit (bit 3 = 1) it happens count×MS_PER_SEC×SEC_PER_MIN ms ticks after.
- R5: Writing address 3 loads the counter and restarts the unit divider. A load in the same cycle as an expiry wins, and no expiry occurs.
- R6: Expiry happens only on the unit tick that takes the count from 1 to 0. A count of 0 never expires.
- R7: On expiry the status bit is set and stays set. Writing 1 to bit 6 clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves it set.
- R8: In level mode (bit 4 = 0) the pin goes low in the cycle after expiry. It stays low until the watchdog stops running or the status is cleared.
- R9: In pulse mode (bit 4 = 1) the pin stays low for 1, 25, 125 or 5000 ms ticks, for width codes 0, 1, 2 and 3 respectively.
- R10: The pin stays high while the output enable is 0, even when expiry has occurred. Setting the output enable later exposes a held level.
- R11: Clearing either enable freezes the counter at once and releases the pin in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wdt_rst_n | output | 1 | Active-low reset request |

## Verification
Two pairs of functions can fall in the same cycle.

- **Expiry and status clear.** The bench writes the clear to the configuration byte on exactly the edge where the counter steps from 1 to 0. The status must then read 1 and the level output must stay low.
- **Expiry and reload.** The bench writes the count register on that same edge. The counter must then hold the new value and the status must read 0.

The write edge is placed by counting clock edges from the enabling write, using the shortened second of the test build.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int PW_BITS = 13;

  typedef enum logic [1:0] {
    A_DEV = 2'd0,
    A_OUT = 2'd1,
    A_CFG = 2'd2,
    A_CNT = 2'd3
  } wdog_addr_e;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       minute;
    logic [1:0] width;
  } wdog_cfg_t;

  // Pulse length in millisecond ticks for a width code.
  function automatic logic [PW_BITS-1:0] pulse_ms(input logic [1:0] code);
    case (code)
      2'd0:    return PW_BITS'(1);
      2'd1:    return PW_BITS'(25);
      2'd2:    return PW_BITS'(125);
      default: return PW_BITS'(5000);
    endcase
  endfunction

  // Read image of the configuration byte.
  function automatic logic [7:0] cfg_image(input wdog_cfg_t c, input logic st);
    return {1'b0, st, c.en, c.pulse, c.minute, 1'b0, c.width};
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       expire,
  input  logic [7:0] cnt,
  output logic       dev_en,
  output logic       out_en,
  output wdog_cfg_t  cfg,
  output logic       status,
  output logic       cnt_load,
  output logic [7:0] load_val,
  output logic       status_clr,
  output logic [7:0] rdata
);

  assign cnt_load   = wr && (addr == A_CNT);
  assign status_clr = wr && (addr == A_CFG) && wdata[6];
  assign load_val   = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_en <= 1'b0;
      out_en <= 1'b0;
      cfg    <= '0;
    end else if (wr) begin
      case (addr)
        A_DEV: dev_en <= wdata[0];
        A_OUT: out_en <= wdata[7];
        A_CFG: cfg    <= '{en: wdata[5], pulse: wdata[4], minute: wdata[3],
                           width: wdata[1:0]};
        default: ;
      endcase
    end
  end

  // Sticky flag: a new expiry outranks a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status <= 1'b0;
    else if (expire)     status <= 1'b1;
    else if (status_clr) status <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_DEV:   rdata = {7'd0, dev_en};
      A_OUT:   rdata = {out_en, 7'd0};
      A_CFG:   rdata = cfg_image(cfg, status);
      default: rdata = cnt;
    endcase
  end

endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic tick_ms,
  input  logic minute,
  output logic unit_tick
);

  localparam int MS_W  = $clog2(MS_PER_SEC);
  localparam int SEC_W = $clog2(SEC_PER_MIN);

  logic [MS_W-1:0]  ms_q;
  logic [SEC_W-1:0] sec_q;
  logic             sec_tick, min_tick;

  assign sec_tick  = run && tick_ms && (ms_q == MS_W'(MS_PER_SEC - 1));
  assign min_tick  = sec_tick && (sec_q == SEC_W'(SEC_PER_MIN - 1));
  assign unit_tick = minute ? min_tick : sec_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else if (!run || restart) begin
      ms_q  <= '0;
      sec_q <= '0;
    end else if (tick_ms) begin
      ms_q <= sec_tick ? '0 : ms_q + MS_W'(1);
      if (sec_tick) sec_q <= min_tick ? '0 : sec_q + SEC_W'(1);
    end
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          unit_tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expire
);

  // Only the 1 -> 0 step fires, and a reload in the same cycle suppresses it.
  assign expire = run && unit_tick && !load && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cnt <= '0;
    else if (load)                           cnt <= load_val;
    else if (run && unit_tick && cnt != '0)  cnt <= cnt - CW'(1);
  end

endmodule

// File: rtl/wdog_outstage.sv
module wdog_outstage
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       run,
  input  logic       pulse,
  input  logic [1:0] width,
  input  logic       tick_ms,
  input  logic       clr,
  output logic       active
);

  logic [PW_BITS-1:0] pw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pw_q   <= '0;
    end else if (expire) begin
      active <= 1'b1;
      pw_q   <= pulse_ms(width);
    end else if (!run || clr) begin
      active <= 1'b0;
    end else if (active && pulse && tick_ms) begin
      if (pw_q == PW_BITS'(1)) active <= 1'b0;
      else                     pw_q   <= pw_q - PW_BITS'(1);
    end
  end

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int MS_PER_SEC  = 1000,
  parameter int SEC_PER_MIN = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_n
);

  localparam int CNT_W = 8;

  logic             dev_en, out_en, status, cnt_load, status_clr;
  logic             running, unit_tick, expire, active;
  logic [CNT_W-1:0] cnt, load_val;
  wdog_cfg_t        cfg;

  assign running = dev_en && cfg.en;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire(expire), .cnt(cnt), .dev_en(dev_en), .out_en(out_en), .cfg(cfg),
    .status(status), .cnt_load(cnt_load), .load_val(load_val),
    .status_clr(status_clr), .rdata(bus_rdata)
  );

  wdog_prescale #(.MS_PER_SEC(MS_PER_SEC), .SEC_PER_MIN(SEC_PER_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(running), .restart(cnt_load),
    .tick_ms(tick_ms), .minute(cfg.minute), .unit_tick(unit_tick)
  );

  wdog_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(running), .unit_tick(unit_tick),
    .load(cnt_load), .load_val(load_val), .cnt(cnt), .expire(expire)
  );

  wdog_outstage u_out (
    .clk(clk), .rst_n(rst_n), .expire(expire), .run(running),
    .pulse(cfg.pulse), .width(cfg.width), .tick_ms(tick_ms),
    .clr(status_clr), .active(active)
  );

  assign wdt_rst_n = !(active && out_en);

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       expire,
  input logic       status,
  input logic       cnt_load,
  input logic       status_clr,
  input logic [7:0] load_val,
  input logic [7:0] cnt,
  input logic       out_en,
  input logic       pin_n,
  input logic       pulse,
  input logic       active
);

  assert_status_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status);

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !status_clr) |=> status);

  assert_zero_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0) |-> !expire);

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> (cnt == $past(load_val)));

  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_load) |=> $stable(cnt));

  assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> pin_n);

  assert_level_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !pulse && run && !status_clr) |=> active);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !active);

endmodule

bind wdog_top wdog_checker u_chk (
  .clk(clk), .rst_n(rst_n), .run(running), .expire(expire), .status(status),
  .cnt_load(cnt_load), .status_clr(status_clr), .load_val(load_val),
  .cnt(cnt), .out_en(out_en), .pin_n(wdt_rst_n), .pulse(cfg.pulse),
  .active(active)
);

// File: tb/tb_wdog_top.sv
module tb_wdog_top;

  localparam int MSS = 4;   // ms ticks per second in this build
  localparam int SPM = 3;   // seconds per minute in this build

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_ms = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       wdt_rst_n;

  int checks = 0;
  int fails  = 0;
  int n, d;
  logic [7:0] v;

  always #5 clk = ~clk;

  wdog_top #(.MS_PER_SEC(MSS), .SEC_PER_MIN(SPM)) dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_n(wdt_rst_n)
  );

  typedef struct packed {
    logic [7:0] cnt;
    logic       minute;
    logic       pulse;
    logic [1:0] w;
    int         lat;   // expected ms ticks to expiry
    int         dur;   // expected low ticks in pulse mode
  } vec_t;

  localparam vec_t VT [5] = '{
    '{8'd3, 1'b0, 1'b0, 2'd0, 3 * MSS,       0},
    '{8'd2, 1'b1, 1'b1, 2'd1, 2 * MSS * SPM, 25},
    '{8'd1, 1'b0, 1'b1, 2'd0, 1 * MSS,       1},
    '{8'd5, 1'b1, 1'b1, 2'd2, 5 * MSS * SPM, 125},
    '{8'd1, 1'b0, 1'b1, 2'd3, 1 * MSS,       5000}
  };

  task automatic wr(input logic [1:0] a, input logic [7:0] dat);
    bus_addr  = a;
    bus_wdata = dat;
    bus_wr    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] val);
    bus_addr = a;
    #1 val = bus_rdata;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL bench timeout: got hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 register reset", v, 0);
    end
    check("R1 pin reset", wdt_rst_n, 1);

    wr(2'd0, 8'h01);
    wr(2'd1, 8'h80);

    // R4 R8 R9 R11: vector table
    for (int i = 0; i < 5; i++) begin
      wr(2'd2, 8'h40);
      wr(2'd3, VT[i].cnt);
      wr(2'd2, {2'b00, 1'b1, VT[i].pulse, VT[i].minute, 1'b0, VT[i].w});
      n = 0;
      while (n < 20000) begin
        @(posedge clk);
        n++;
        @(negedge clk);
        if (!wdt_rst_n) break;
      end
      check("R4 expiry latency", n, VT[i].lat);
      if (VT[i].pulse) begin
        d = 0;
        while (!wdt_rst_n && d < 20000) begin
          d++;
          @(negedge clk);
        end
        check("R9 pulse width", d, VT[i].dur);
        rd(2'd2, v);
        check("R7 status after pulse", v[6], 1);
      end else begin
        repeat (50) @(negedge clk);
        check("R8 level held", wdt_rst_n, 0);
        wr(2'd2, 8'h00);
        @(negedge clk);
        check("R11 disable releases", wdt_rst_n, 1);
      end
    end

    // R3: device enable off blocks counting
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd5);
    wr(2'd2, 8'h20);
    repeat (30) @(negedge clk);
    rd(2'd3, v);
    check("R3 count held without device enable", v, 5);
    check("R3 pin idle", wdt_rst_n, 1);
    // R11: one decrement, then disable freezes the count
    wr(2'd0, 8'h01);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h00);
    repeat (20) @(negedge clk);
    rd(2'd3, v);
    check("R11 count frozen on disable", v, 4);

    // R6: zero count never fires
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h20);
    repeat (100) @(negedge clk);
    check("R6 pin idle at zero", wdt_rst_n, 1);
    rd(2'd2, v);
    check("R6 no status at zero", v[6], 0);

    // R5: periodic reload keeps it alive
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd2);
    wr(2'd2, 8'h20);
    for (int k = 0; k < 6; k++) begin
      repeat (4) @(negedge clk);
      wr(2'd3, 8'd2);
    end
    rd(2'd2, v);
    check("R5 kicked no status", v[6], 0);
    check("R5 kicked pin idle", wdt_rst_n, 1);

    // R5: reload on the expiry edge wins
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'h20);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'd9);
    rd(2'd3, v);
    check("R5 reload value on expiry edge", v, 9);
    rd(2'd2, v);
    check("R5 no status when reload collides", v[6], 0);
    check("R5 pin idle when reload collides", wdt_rst_n, 1);

    // R7: clear on the expiry edge loses
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'h20);
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h60);
    rd(2'd2, v);
    check("R7 set wins over clear", v[6], 1);
    check("R8 level low after collision", wdt_rst_n, 0);
    wr(2'd2, 8'h20);
    rd(2'd2, v);
    check("R7 write zero keeps status", v[6], 1);
    check("R8 level still low", wdt_rst_n, 0);
    wr(2'd2, 8'h60);
    rd(2'd2, v);
    check("R7 write one clears", v[6], 0);
    check("R8 clear releases level", wdt_rst_n, 1);

    // R10: output enable gates the pin
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h40);
    wr(2'd3, 8'd1);
    wr(2'd2, 8'h20);
    repeat (10) @(negedge clk);
    rd(2'd2, v);
    check("R10 status set while gated", v[6], 1);
    check("R10 pin gated", wdt_rst_n, 1);
    wr(2'd1, 8'h80);
    check("R10 pin exposed", wdt_rst_n, 0);
    wr(2'd2, 8'h40);

    // R2: register layout and reserved bits
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h3F);
    rd(2'd2, v);
    check("R2 config image", v, 8'h3B);
    rd(2'd1, v);
    check("R2 output enable image", v, 8'h80);
    rd(2'd0, v);
    check("R2 device enable image", v, 8'h01);
    wr(2'd3, 8'hA5);
    rd(2'd3, v);
    check("R2 count image", v, 8'hA5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule